// File: doc/BRIEF.md
# Vector Whole-Register and Mask Load Sequencer

This block runs the two vector load forms that do not depend on the vector type setting. In whole-register mode it fills a group of 1, 2, 4 or 8 adjacent vector registers from consecutive register-sized chunks of memory. The active vector length, the start index and the mask register play no part in this mode. In mask mode it fills only the low ceil(vl/8) bytes of one register from the base address. Each register takes one memory beat. Each beat goes out on a valid/ready request channel, and its data comes back on a valid/ready response channel. Received data goes to the vector register file through a byte-enabled write port.

A load starts with a one-cycle `start` pulse while the block is idle. The pulse carries the mode, destination index, group size, base address, current vl and the vector-enable flag. The block ends every accepted start with exactly one one-cycle pulse: `done`, `illegal` or `fault`. `vs_dirty` and `vstart_clr` pulse alongside that outcome whenever the vector state has to change. Request back-pressure: once `mem_req_valid` is high, it and `mem_req_addr` hold until `mem_req_ready` is seen. Response back-pressure: `mem_rsp_ready` is high only while a beat is outstanding, and the response is taken in the first cycle with `mem_rsp_valid` high.

Top module: `vld_seq`

## Requirements
- R1: If `vec_en` is low at start, `illegal` pulses one cycle later. No memory request, register write, `vs_dirty` or `vstart_clr` follows, in either mode.
- R2: In whole-register mode (`mode`=0), a group size other than 1, 2, 4 or 8, or a `dst_idx` that is not a multiple of the group size, gives `illegal` with no memory request.
- R3: In whole-register mode every register write has all VLENB byte enables set, whatever the value of `cur_vl`.
- R4: In whole-register mode, group register k is written to index `dst_idx`+k with the k-th response. That response comes from a request at `base_addr` + k*VLENB. Requests are issued one at a time in ascending k.
- R5: A response with `mem_rsp_err` set on group register k>0 gives `fault` with `vs_dirty` and `vstart_clr` in the same cycle. Registers 0..k-1 stay written.
- R6: A response with `mem_rsp_err` set on the first register gives `fault` with neither `vs_dirty` nor `vstart_clr`, and no register write.
- R7: In mask mode (`mode`=1) with `cur_vl`>0, one request is made at `base_addr`. The write goes to `dst_idx`, with byte enable bit i set exactly when i < ceil(`cur_vl`/8).
- R8: In mask mode with `cur_vl`=0, no request is issued. `done`, `vs_dirty` and `vstart_clr` pulse one cycle after start.
- R9: On successful completion, `done`, `vs_dirty` and `vstart_clr` pulse in the cycle of the last register write.
- R10: `busy` is high from the cycle after an accepted start until the outcome pulse. A `start` while busy is ignored. After reset the block is idle with all outputs low.
- R11: `mem_req_valid` and `mem_req_addr` hold steady until `mem_req_ready`. `mem_rsp_ready` is never high together with `mem_req_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, taken only when idle |
| mode | input | 1 | 0 whole-register, 1 mask |
| dst_idx | input | IDXW (5) | First destination register |
| grp_cnt | input | CNTW (4) | Registers in the group (whole-register mode) |
| base_addr | input | AW (32) | Byte address of the first beat |
| cur_vl | input | VLW (8) | Current vector length in elements |
| vec_en | input | 1 | Vector instructions enabled |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | AW (32) | Read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Block waiting for read data |
| mem_rsp_data | input | VLEN (128) | One register of read data |
| mem_rsp_err | input | 1 | Access fault on this beat |
| rf_we | output | 1 | Register write strobe |
| rf_waddr | output | IDXW (5) | Register written |
| rf_wdata | output | VLEN (128) | Write data |
| rf_wbe | output | VLENB (16) | Byte enables |
| busy | output | 1 | Load in progress |
| done | output | 1 | Successful completion pulse |
| illegal | output | 1 | Illegal-instruction pulse |
| fault | output | 1 | Access-fault pulse |
| vs_dirty | output | 1 | Mark vector state dirty |
| vstart_clr | output | 1 | Reset vstart to zero |

## Verification
The hardest case to reach is a fault partway through a group. Prior registers must stay written, and the state-update pulses must accompany the fault. A first-beat fault, with the pulses withheld, must be told apart from it. The bench's memory responder is told which beat index to answer with an error. It then runs a two-register group faulting on the second beat and a group faulting on the first beat. A stalling responder exercises request hold, and a second start injected mid-load with vector instructions disabled proves that starts while busy are ignored.

// File: rtl/vld_pkg.sv
package vld_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RSP  = 2'd2
  } vld_state_e;

  typedef enum logic {
    MODE_WHOLE = 1'b0,
    MODE_MASK  = 1'b1
  } vld_mode_e;
endpackage

// File: rtl/vld_legal.sv
module vld_legal #(
  parameter int IDXW   = 5,
  parameter int CNTW   = 4,
  parameter int NREG   = 32,
  parameter int MAXGRP = 8
) (
  input  logic            vec_en,
  input  logic            mode,
  input  logic [IDXW-1:0] dst,
  input  logic [CNTW-1:0] cnt,
  output logic            bad
);
  logic pow2;
  logic misaligned;
  logic overrun;

  always_comb begin
    pow2       = (cnt != '0) && ((cnt & (cnt - 1'b1)) == '0) && (int'(cnt) <= MAXGRP);
    misaligned = pow2 && ((int'(dst) % int'(cnt)) != 0);
    overrun    = (int'(dst) + int'(cnt)) > NREG;
    bad        = !vec_en || ((mode == 1'b0) && (!pow2 || misaligned || overrun));
  end
endmodule

// File: rtl/vld_byte_mask.sv
module vld_byte_mask #(
  parameter int VLENB = 16,
  parameter int VLW   = 8
) (
  input  logic [VLW-1:0]   vl,
  output logic [VLENB-1:0] be
);
  logic [VLW:0] nbytes;
  assign nbytes = ((VLW+1)'(vl) + (VLW+1)'(7)) >> 3;

  for (genvar i = 0; i < VLENB; i++) begin : g_be
    assign be[i] = nbytes > (VLW+1)'(i);
  end
endmodule

// File: rtl/vld_beat_ctr.sv
module vld_beat_ctr #(
  parameter int CNTW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            inc,
  input  logic [CNTW-1:0] limit,
  output logic [CNTW-1:0] idx,
  output logic            last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx <= '0;
    else if (clr) idx <= '0;
    else if (inc) idx <= idx + 1'b1;
  end

  assign last = (idx == limit - 1'b1);
endmodule

// File: rtl/vld_seq.sv
module vld_seq
  import vld_pkg::*;
#(
  parameter int VLEN   = 128,
  parameter int AW     = 32,
  parameter int NREG   = 32,
  parameter int MAXGRP = 8,
  localparam int VLENB = VLEN / 8,
  localparam int IDXW  = $clog2(NREG),
  localparam int VLW   = $clog2(VLEN + 1),
  localparam int CNTW  = $clog2(MAXGRP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode,
  input  logic [IDXW-1:0]  dst_idx,
  input  logic [CNTW-1:0]  grp_cnt,
  input  logic [AW-1:0]    base_addr,
  input  logic [VLW-1:0]   cur_vl,
  input  logic             vec_en,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [AW-1:0]    mem_req_addr,
  input  logic             mem_rsp_valid,
  output logic             mem_rsp_ready,
  input  logic [VLEN-1:0]  mem_rsp_data,
  input  logic             mem_rsp_err,
  output logic             rf_we,
  output logic [IDXW-1:0]  rf_waddr,
  output logic [VLEN-1:0]  rf_wdata,
  output logic [VLENB-1:0] rf_wbe,
  output logic             busy,
  output logic             done,
  output logic             illegal,
  output logic             fault,
  output logic             vs_dirty,
  output logic             vstart_clr
);
  localparam int SH = $clog2(VLENB);

  vld_state_e       st;
  logic             mode_q;
  logic [IDXW-1:0]  dst_q;
  logic [CNTW-1:0]  lim_q;
  logic [AW-1:0]    base_q;
  logic [VLENB-1:0] be_q;
  logic [CNTW-1:0]  beat;
  logic             last_beat;
  logic             bad_c;
  logic [VLENB-1:0] vl_be;
  logic             accept;
  logic             rsp_take;
  logic             rsp_ok;

  vld_legal #(.IDXW(IDXW), .CNTW(CNTW), .NREG(NREG), .MAXGRP(MAXGRP)) u_legal (
    .vec_en (vec_en),
    .mode   (mode),
    .dst    (dst_idx),
    .cnt    (grp_cnt),
    .bad    (bad_c)
  );

  vld_byte_mask #(.VLENB(VLENB), .VLW(VLW)) u_bmask (
    .vl (cur_vl),
    .be (vl_be)
  );

  assign accept   = start && (st == ST_IDLE);
  assign rsp_take = (st == ST_RSP) && mem_rsp_valid;
  assign rsp_ok   = rsp_take && !mem_rsp_err;

  vld_beat_ctr #(.CNTW(CNTW)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .inc   (rsp_ok && !last_beat),
    .limit (lim_q),
    .idx   (beat),
    .last  (last_beat)
  );

  assign mem_req_valid = (st == ST_REQ);
  assign mem_rsp_ready = (st == ST_RSP);
  assign mem_req_addr  = base_q + (AW'(beat) << SH);
  assign busy          = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      mode_q     <= 1'b0;
      dst_q      <= '0;
      lim_q      <= '0;
      base_q     <= '0;
      be_q       <= '0;
      rf_we      <= 1'b0;
      rf_waddr   <= '0;
      rf_wdata   <= '0;
      rf_wbe     <= '0;
      done       <= 1'b0;
      illegal    <= 1'b0;
      fault      <= 1'b0;
      vs_dirty   <= 1'b0;
      vstart_clr <= 1'b0;
    end else begin
      rf_we      <= 1'b0;
      done       <= 1'b0;
      illegal    <= 1'b0;
      fault      <= 1'b0;
      vs_dirty   <= 1'b0;
      vstart_clr <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (accept) begin
            if (bad_c) begin
              illegal <= 1'b1;
            end else if ((mode == MODE_MASK) && (cur_vl == '0)) begin
              done       <= 1'b1;
              vs_dirty   <= 1'b1;
              vstart_clr <= 1'b1;
            end else begin
              mode_q <= mode;
              dst_q  <= dst_idx;
              base_q <= base_addr;
              lim_q  <= (mode == MODE_MASK) ? CNTW'(1) : grp_cnt;
              be_q   <= (mode == MODE_MASK) ? vl_be : '1;
              st     <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (mem_req_ready) st <= ST_RSP;
        end
        ST_RSP: begin
          if (rsp_take) begin
            if (mem_rsp_err) begin
              fault <= 1'b1;
              if (beat != '0) begin
                vs_dirty   <= 1'b1;
                vstart_clr <= 1'b1;
              end
              st <= ST_IDLE;
            end else begin
              rf_we    <= 1'b1;
              rf_waddr <= dst_q + IDXW'(beat);
              rf_wdata <= mem_rsp_data;
              rf_wbe   <= be_q;
              if (last_beat) begin
                done       <= 1'b1;
                vs_dirty   <= 1'b1;
                vstart_clr <= 1'b1;
                st         <= ST_IDLE;
              end else begin
                st <= ST_REQ;
              end
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vld_chk.sv
module vld_chk #(
  parameter int AW    = 32,
  parameter int VLENB = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [AW-1:0]    mem_req_addr,
  input logic             mem_rsp_ready,
  input logic             rf_we,
  input logic [VLENB-1:0] rf_wbe,
  input logic             done,
  input logic             illegal,
  input logic             fault,
  input logic             vs_dirty,
  input logic             vstart_clr
);
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_valid && mem_rsp_ready));

  a_r9_done_updates: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> vs_dirty && vstart_clr);

  a_r1_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !rf_we && !vs_dirty && !vstart_clr);

  a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, illegal, fault}));

  a_r10_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);

  a_r5_dirty_with_end: assert property (@(posedge clk) disable iff (!rst_n)
    vs_dirty |-> done || fault);

  a_r7_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> rf_wbe[0]);
endmodule

bind vld_seq vld_chk #(.AW(AW), .VLENB(VLENB)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_ready (mem_rsp_ready),
  .rf_we         (rf_we),
  .rf_wbe        (rf_wbe),
  .done          (done),
  .illegal       (illegal),
  .fault         (fault),
  .vs_dirty      (vs_dirty),
  .vstart_clr    (vstart_clr)
);

// File: tb/tb_vld_seq.sv
`timescale 1ns/1ps
module tb_vld_seq;
  localparam int VLEN  = 128;
  localparam int VLENB = 16;
  localparam int AW    = 32;

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0, mode = 0, vec_en = 0;
  logic [4:0] dst_idx = '0;
  logic [3:0] grp_cnt = '0;
  logic [AW-1:0] base_addr = '0;
  logic [7:0] cur_vl = '0;
  logic mem_req_ready = 0, mem_rsp_valid = 0, mem_rsp_err = 0;
  logic [VLEN-1:0] mem_rsp_data = '0;
  logic mem_req_valid, mem_rsp_ready, rf_we, busy, done, illegal, fault, vs_dirty, vstart_clr;
  logic [AW-1:0] mem_req_addr;
  logic [4:0] rf_waddr;
  logic [VLEN-1:0] rf_wdata;
  logic [VLENB-1:0] rf_wbe;

  vld_seq dut (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  int n_wr, n_req;
  logic [4:0] wr_addr [16];
  logic [VLEN-1:0] wr_data [16];
  logic [VLENB-1:0] wr_be [16];
  logic [AW-1:0] req_addr [16];
  bit got_done, got_fault, got_ill, got_dirty, got_vclr, hold_bad;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [VLEN-1:0] pat(input int beat);
    logic [VLEN-1:0] r;
    for (int i = 0; i < VLENB; i++) r[i*8 +: 8] = 8'(8'hA0 + beat * VLENB + i);
    return r;
  endfunction

  task automatic run_op(input logic m, input logic [4:0] d, input logic [3:0] c,
                        input logic [AW-1:0] b, input logic [7:0] vl, input logic en,
                        input int fault_beat, input int stall, input bit restart);
    int st_cnt = 0;
    logic [AW-1:0] held = '0;
    bit holding = 0;
    n_wr = 0; n_req = 0; got_done = 0; got_fault = 0; got_ill = 0;
    got_dirty = 0; got_vclr = 0; hold_bad = 0;
    @(negedge clk);
    start = 1; mode = m; dst_idx = d; grp_cnt = c; base_addr = b; cur_vl = vl; vec_en = en;
    @(negedge clk);
    start = 0;
    for (int it = 0; it < 200; it++) begin
      if (rf_we && n_wr < 16) begin
        wr_addr[n_wr] = rf_waddr; wr_data[n_wr] = rf_wdata; wr_be[n_wr] = rf_wbe; n_wr++;
      end
      if (done || fault || illegal) begin
        got_done = done; got_fault = fault; got_ill = illegal;
        got_dirty = vs_dirty; got_vclr = vstart_clr;
        break;
      end
      if (restart && it == 1) begin
        start = 1; vec_en = 0; dst_idx = 5'd0; mode = 0; grp_cnt = 4'd3;
      end else begin
        start = 0;
      end
      if (mem_req_valid) begin
        if (holding && mem_req_addr !== held) hold_bad = 1;
        if (st_cnt < stall) begin
          st_cnt++; mem_req_ready = 0; holding = 1; held = mem_req_addr;
        end else begin
          mem_req_ready = 1; holding = 0; st_cnt = 0;
          if (n_req < 16) req_addr[n_req] = mem_req_addr;
          n_req++;
        end
      end else begin
        mem_req_ready = 0;
      end
      if (mem_rsp_ready) begin
        mem_rsp_valid = 1; mem_rsp_data = pat(n_req - 1); mem_rsp_err = (n_req - 1 == fault_beat);
      end else begin
        mem_rsp_valid = 0; mem_rsp_err = 0;
      end
      @(negedge clk);
    end
    start = 0; mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_err = 0; vec_en = 1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!busy && !mem_req_valid && !rf_we && !done && !illegal && !fault && !vs_dirty && !vstart_clr,
        "R10 reset idle", {busy, mem_req_valid, rf_we, done, illegal, fault, vs_dirty, vstart_clr}, 0);
  endtask

  task automatic t_disabled();
    run_op(1'b0, 5'd4, 4'd4, 32'h100, 8'd8, 1'b0, -1, 0, 0);
    chk(got_ill && n_req == 0 && n_wr == 0 && !got_dirty && !got_vclr, "R1 disabled whole", n_req, 0);
    run_op(1'b1, 5'd4, 4'd1, 32'h100, 8'd8, 1'b0, -1, 0, 0);
    chk(got_ill && n_req == 0 && n_wr == 0 && !got_dirty, "R1 disabled mask", n_req, 0);
  endtask

  task automatic t_bad_group();
    run_op(1'b0, 5'd2, 4'd4, 32'h200, 8'd0, 1'b1, -1, 0, 0);
    chk(got_ill && n_req == 0, "R2 misaligned dst", n_req, 0);
    run_op(1'b0, 5'd3, 4'd3, 32'h200, 8'd0, 1'b1, -1, 0, 0);
    chk(got_ill && n_req == 0, "R2 count 3", n_req, 0);
  endtask

  task automatic t_whole(input logic [4:0] d, input logic [3:0] c, input int stall);
    logic [AW-1:0] b = 32'h0000_1000;
    run_op(1'b0, d, c, b, 8'd5, 1'b1, -1, stall, 0);
    chk(got_done && got_dirty && got_vclr, "R9 done with updates", {got_done, got_dirty, got_vclr}, 3'b111);
    chk(n_wr == int'(c) && n_req == int'(c), "R4 beat count", n_wr, c);
    chk(!hold_bad, "R11 request held under stall", hold_bad, 0);
    for (int k = 0; k < int'(c) && k < 16; k++) begin
      chk(req_addr[k] == b + AW'(k * VLENB), "R4 address", req_addr[k], b + AW'(k * VLENB));
      chk(wr_addr[k] == d + 5'(k), "R4 dest index", wr_addr[k], d + 5'(k));
      chk(wr_data[k] == pat(k), "R4 data", wr_data[k], pat(k));
      chk(wr_be[k] == '1, "R3 full enables", wr_be[k], 16'hFFFF);
    end
  endtask

  task automatic t_fault_later();
    run_op(1'b0, 5'd4, 4'd2, 32'h3000, 8'd1, 1'b1, 1, 0, 0);
    chk(got_fault && got_dirty && got_vclr, "R5 later fault updates", {got_fault, got_dirty, got_vclr}, 3'b111);
    chk(n_wr == 1 && wr_addr[0] == 5'd4, "R5 first reg kept", n_wr, 1);
  endtask

  task automatic t_fault_first();
    run_op(1'b0, 5'd8, 4'd8, 32'h4000, 8'd1, 1'b1, 0, 0, 0);
    chk(got_fault && !got_dirty && !got_vclr, "R6 first fault quiet", {got_fault, got_dirty, got_vclr}, 3'b100);
    chk(n_wr == 0, "R6 no write", n_wr, 0);
  endtask

  task automatic t_mask(input logic [7:0] vl, input logic [15:0] exp_be);
    run_op(1'b1, 5'd6, 4'd0, 32'h5000, vl, 1'b1, -1, 1, 0);
    chk(n_req == 1 && req_addr[0] == 32'h5000, "R7 single request", n_req, 1);
    chk(n_wr == 1 && wr_addr[0] == 5'd6 && wr_be[0] == exp_be, "R7 byte enables", wr_be[0], exp_be);
    chk(got_done && got_dirty && got_vclr, "R9 mask done", {got_done, got_dirty, got_vclr}, 3'b111);
  endtask

  task automatic t_mask_zero();
    run_op(1'b1, 5'd6, 4'd0, 32'h5000, 8'd0, 1'b1, -1, 0, 0);
    chk(n_req == 0 && n_wr == 0 && got_done && got_dirty && got_vclr, "R8 vl zero", n_req, 0);
  endtask

  task automatic t_restart();
    run_op(1'b0, 5'd16, 4'd2, 32'h6000, 8'd0, 1'b1, -1, 2, 1);
    chk(!got_ill && got_done && n_wr == 2 && wr_addr[0] == 5'd16, "R10 start while busy ignored", n_wr, 2);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_bad_group();
    t_whole(5'd8, 4'd4, 2);
    t_whole(5'd24, 4'd8, 0);
    t_whole(5'd31, 4'd1, 1);
    t_fault_later();
    t_fault_first();
    t_mask(8'd13, 16'h0003);
    t_mask(8'd1, 16'h0001);
    t_mask(8'd128, 16'hFFFF);
    t_mask_zero();
    t_restart();
    finished = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule